// File: doc/BRIEF.md
# Burst Read Streamer

This block turns a region of memory into a sequential data stream. A single start pulse provides a byte base address and a length counted in 64-byte beats. The block then walks the region with incrementing read bursts on an AXI4 read-address channel. It collects the returned read data in a local buffer and hands it out, in address order, on an AXI4-Stream master port of 512-bit beats. The last beat is flagged so that downstream logic knows where the buffer ends.

Bursts are cut to a configurable maximum length and are never allowed to straddle a 4 KB page. The block counts the beats it has requested but not yet delivered downstream. It issues a new burst only when the whole burst is guaranteed to fit in the local buffer, so read data can be accepted at once whenever it arrives. A read response other than OKAY sets a sticky error flag. Data keeps flowing regardless, so the stream always carries exactly the requested number of beats.

Top module: `burst_stream_reader`

## Requirements
- R1: During and right after reset, busy_o, done_o, err_o, m_arvalid and s_tvalid are all low.
- R2: Stream beat i carries the read data returned for byte address A + 64*i, where A is base_addr_i with its low six bits forced to zero. Beats appear in that order.
- R3: Every request uses arsize 3'b110 (64 bytes) and arburst 2'b01 (incrementing), with arlen = beats-1. It holds at most MAX_BURST beats (64 by default) and never crosses a 4096-byte address boundary. Consecutive requests are contiguous and together cover exactly the requested length.
- R4: Once s_tvalid is high, it and s_tdata/s_tlast stay unchanged until s_tready is seen high.
- R5: s_tlast is high on stream beat index len-1 and on no other beat of the job.
- R6: busy_o is high from the cycle after an accepted start until the final stream transfer. done_o pulses high for one cycle in the cycle right after that transfer, and busy_o is then low.
- R7: A start with a length of zero pulses done_o in the cycle after the start. It issues no read request and no stream beat, and busy_o stays low.
- R8: Any read beat accepted with rresp not equal to 2'b00 sets err_o. All beats of the job, including that one, are still streamed. err_o stays set until the next accepted start clears it.
- R9: Beats requested but not yet delivered on the stream never exceed FIFO_DEPTH (128 by default). With the stream stalled, issuing stops at that limit. m_rready is low only when the buffer is full.
- R10: A start pulse while busy_o is high is ignored. No extra request, beat or done pulse results from it.
- R11: Once m_arvalid is high, it, m_araddr and m_arlen stay unchanged until m_arready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_addr_i | input | 64 | Byte base address of the buffer |
| len_i | input | 16 | Buffer length in 64-byte beats |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky read-error flag |
| m_arvalid | output | 1 | Read request valid |
| m_arready | input | 1 | Read request accepted |
| m_araddr | output | 64 | Burst start address |
| m_arlen | output | 8 | Burst beats minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data accepted |
| m_rdata | input | 512 | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last beat of a burst (not needed internally) |
| s_tvalid | output | 1 | Stream beat valid |
| s_tready | input | 1 | Stream beat accepted |
| s_tdata | output | 512 | Stream payload |
| s_tlast | output | 1 | Final beat of the buffer |

## Verification
The hardest state to reach is a buffer loaded to its full credit limit, with requests held back, while the read side still has data in flight. The bench holds s_tready low through a long job until two full bursts are outstanding. It confirms that no third request appears and nothing is streamed, then releases the stream and checks the whole buffer. Page splitting is reached by starting three beats short of a 4 KB boundary. Read errors are reached by having the memory model flag one chosen beat address.

// File: rtl/rdstr_pkg.sv
package rdstr_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam int         PAGE_BYTES = 4096;
endpackage

// File: rtl/rdstr_burst_gen.sv
module rdstr_burst_gen #(
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 64,
  parameter int MAX_BURST  = 64,
  parameter int DEPTH      = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              pop_i,
  output logic              arvalid_o,
  input  logic              arready_i,
  output logic [ADDR_W-1:0] araddr_o,
  output logic [7:0]        arlen_o
);
  localparam int OFF_W      = $clog2(BEAT_BYTES);
  localparam int PAGE_BEATS = rdstr_pkg::PAGE_BYTES / BEAT_BYTES;
  localparam int PG_W       = $clog2(PAGE_BEATS);
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int CAP        = (MAX_BURST < PAGE_BEATS) ? MAX_BURST : PAGE_BEATS;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  resv_q, resv_d;
  logic [LEN_W-1:0]  page_left, lim, blen;
  logic [CNT_W:0]    need;
  logic              credit_ok, ar_fire;
  logic [OFF_W-1:0]  unused_low;

  assign unused_low = base_i[OFF_W-1:0];

  always_comb begin
    page_left = LEN_W'(PAGE_BEATS) - LEN_W'(addr_q[OFF_W +: PG_W]);
    lim       = (page_left < LEN_W'(CAP)) ? page_left : LEN_W'(CAP);
    blen      = (rem_q < lim) ? rem_q : lim;
    need      = (CNT_W+1)'(resv_q) + (CNT_W+1)'(blen);
  end

  assign credit_ok = (need <= (CNT_W+1)'(DEPTH));
  assign arvalid_o = (rem_q != '0) && credit_ok;
  assign ar_fire   = arvalid_o && arready_i;
  assign araddr_o  = addr_q;
  assign arlen_o   = 8'(blen - LEN_W'(1));

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    resv_d = resv_q;
    if (accept_i) begin
      addr_d = {base_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      rem_d  = len_i;
    end else if (ar_fire) begin
      addr_d = addr_q + (ADDR_W'(blen) << OFF_W);
      rem_d  = rem_q - blen;
    end
    if (ar_fire) resv_d = resv_d + CNT_W'(blen);
    if (pop_i)   resv_d = resv_d - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      resv_q <= '0;
    end else begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      resv_q <= resv_d;
    end
  end

  // R11
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid_o && !arready_i |=> arvalid_o && $stable(araddr_o) && $stable(arlen_o));

  // R3
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid_o |-> ((PG_W+1)'(araddr_o[OFF_W +: PG_W]) + (PG_W+1)'(arlen_o)) < (PG_W+1)'(PAGE_BEATS));

  // R3
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid_o |-> (int'(arlen_o) < MAX_BURST));

  // R9
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(resv_q) <= DEPTH);
endmodule

// File: rtl/rdstr_beat_fifo.sv
module rdstr_beat_fifo #(
  parameter int W     = 512,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
    if (pop_i)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    if (push_i && !pop_i) cnt_d = cnt_q + CNT_W'(1);
    if (pop_i && !push_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // R9
  fifo_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rdstr_stream_tail.sv
module rdstr_stream_tail #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pop_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             last_o
);
  logic [LEN_W-1:0] total_q, total_d, idx_q, idx_d;
  logic             busy_q, busy_d, done_q, done_d;

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign last_o = busy_q && (idx_q == total_q - LEN_W'(1));

  always_comb begin
    total_d = total_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (accept_i) begin
      total_d = len_i;
      idx_d   = '0;
      busy_d  = (len_i != '0);
      done_d  = (len_i == '0);
    end else if (pop_i) begin
      idx_d = idx_q + LEN_W'(1);
      if (last_o) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      total_q <= total_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  // R6
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && last_o |=> done_o && !busy_o);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i && (len_i == '0) |=> done_o && !busy_o);
endmodule

// File: rtl/burst_stream_reader.sv
module burst_stream_reader
  import rdstr_pkg::*;
#(
  parameter int DATA_W     = 512,
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 64,
  parameter int FIFO_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  output logic              s_tvalid,
  input  logic              s_tready,
  output logic [DATA_W-1:0] s_tdata,
  output logic              s_tlast
);
  localparam int BEAT_BYTES = DATA_W / 8;

  logic accept, pop, push, full, empty, err_q, err_d;
  logic unused_rlast;

  assign unused_rlast = m_rlast;
  assign accept    = start_i && !busy_o;
  assign pop       = s_tvalid && s_tready;
  assign push      = m_rvalid && m_rready;
  assign m_rready  = !full;
  assign s_tvalid  = !empty;
  assign m_arsize  = 3'($clog2(BEAT_BYTES));
  assign m_arburst = BURST_INCR;
  assign err_o     = err_q;

  rdstr_burst_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES),
    .MAX_BURST(MAX_BURST), .DEPTH(FIFO_DEPTH)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .base_i(base_addr_i),
    .len_i(len_i), .pop_i(pop), .arvalid_o(m_arvalid), .arready_i(m_arready),
    .araddr_o(m_araddr), .arlen_o(m_arlen)
  );

  rdstr_beat_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(m_rdata), .pop_i(pop),
    .dout_o(s_tdata), .full_o(full), .empty_o(empty)
  );

  rdstr_stream_tail #(.LEN_W(LEN_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .len_i(len_i), .pop_i(pop),
    .busy_o(busy_o), .done_o(done_o), .last_o(s_tlast)
  );

  always_comb begin
    err_d = err_q;
    if (accept) err_d = 1'b0;
    else if (push && (m_rresp != RESP_OKAY)) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && (m_rresp != RESP_OKAY) |=> err_o);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> m_rready);

  // R4
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_tvalid && !s_tready |=> s_tvalid && $stable(s_tdata) && $stable(s_tlast));
endmodule

// File: tb/sim_burst_stream_reader.sv
module sim_burst_stream_reader;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [63:0]  base_addr_i;
  logic [15:0]  len_i;
  logic         busy_o, done_o, err_o;
  logic         m_arvalid, m_arready;
  logic [63:0]  m_araddr;
  logic [7:0]   m_arlen;
  logic [2:0]   m_arsize;
  logic [1:0]   m_arburst;
  logic         m_rvalid, m_rready, m_rlast;
  logic [511:0] m_rdata;
  logic [1:0]   m_rresp;
  logic         s_tvalid, s_tready, s_tlast;
  logic [511:0] s_tdata;

  always #5 clk = ~clk;

  burst_stream_reader u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .len_i(len_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
    .m_rresp(m_rresp), .m_rlast(m_rlast), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // stimulus modes, written only by the main sequence
  int          t_mode = 0;
  int          r_mode = 0;
  int          a_mode = 0;
  bit          err_en = 1'b0;
  logic [63:0] err_addr = '0;

  // observation state, written only by the monitor
  int          cyc = 0;
  logic [63:0] pend_addr [$];
  int          pend_len  [$];
  int          beat_in_burst = 0;
  int          r_hs_cnt = 0;
  logic [63:0] log_addr  [$];
  int          log_beats [$];
  logic [511:0] s_log    [$];
  bit          s_last_log [$];
  int          last_hs_cyc = 0;
  int          done_cnt = 0;
  int          done_cyc = 0;
  int          req_beats = 0;
  int          out_beats = 0;
  bit          ar_bad = 0, ar_drop = 0, t_drop = 0;
  bit          p_ar_stall = 0, p_t_stall = 0;
  logic [63:0] p_araddr;
  logic [7:0]  p_arlen;
  logic [511:0] p_tdata;
  bit          p_tlast;

  function automatic logic [511:0] pat(input logic [63:0] a);
    return {8{a ^ 64'h5A5A_0000_C3C3_0000}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (p_ar_stall && (!m_arvalid || m_araddr != p_araddr || m_arlen != p_arlen)) ar_drop = 1;
      if (p_t_stall && (!s_tvalid || s_tdata != p_tdata || s_tlast != p_tlast)) t_drop = 1;
      p_ar_stall = m_arvalid && !m_arready;
      p_araddr = m_araddr; p_arlen = m_arlen;
      p_t_stall = s_tvalid && !s_tready;
      p_tdata = s_tdata; p_tlast = s_tlast;
      if (m_arvalid && m_arready) begin
        pend_addr.push_back(m_araddr);
        pend_len.push_back(int'(m_arlen) + 1);
        log_addr.push_back(m_araddr);
        log_beats.push_back(int'(m_arlen) + 1);
        req_beats += int'(m_arlen) + 1;
        if (m_arsize != 3'b110 || m_arburst != 2'b01) ar_bad = 1;
      end
      if (m_rvalid && m_rready) begin
        r_hs_cnt++;
        beat_in_burst++;
        if (beat_in_burst == pend_len[0]) begin
          void'(pend_addr.pop_front());
          void'(pend_len.pop_front());
          beat_in_burst = 0;
        end
      end
      if (s_tvalid && s_tready) begin
        s_log.push_back(s_tdata);
        s_last_log.push_back(s_tlast);
        last_hs_cyc = cyc;
        out_beats++;
      end
      if (done_o) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  // memory and sink model
  initial begin
    int seen;
    logic [63:0] a;
    seen = 0;
    m_arready = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_rresp = 2'b00;
    m_rlast = 1'b0; s_tready = 1'b0;
    forever begin
      @(negedge clk);
      m_arready = (a_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (!(m_rvalid && r_hs_cnt == seen)) begin
        seen = r_hs_cnt;
        if (pend_addr.size() > 0 && (r_mode == 0 || (cyc % 4) != 1)) begin
          a = pend_addr[0] + 64'(beat_in_burst) * 64;
          m_rvalid = 1'b1;
          m_rdata  = pat(a);
          m_rlast  = (beat_in_burst == pend_len[0] - 1);
          m_rresp  = (err_en && a == err_addr) ? 2'b10 : 2'b00;
        end else begin
          m_rvalid = 1'b0;
        end
      end
      case (t_mode)
        0:       s_tready = 1'b1;
        1:       s_tready = (cyc % 5) < 2;
        default: s_tready = 1'b0;
      endcase
    end
  end

  task automatic start_job(input logic [63:0] base, input int len);
    @(negedge clk);
    base_addr_i = base;
    len_i = 16'(len);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    int t;
    t = 0;
    while (done_cnt == prev && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic check_stream(input logic [63:0] base, input int len,
                              input int mark, input string req);
    int bad_data, bad_last;
    logic [63:0] a0;
    bad_data = 0; bad_last = 0;
    a0 = {base[63:6], 6'b0};
    chk(s_log.size() - mark == len, req, "stream beat count", s_log.size() - mark, len);
    for (int i = 0; i < len && mark + i < s_log.size(); i++) begin
      if (s_log[mark + i] != pat(a0 + 64'(i) * 64)) bad_data++;
      if (s_last_log[mark + i] != (i == len - 1)) bad_last++;
    end
    chk(bad_data == 0, req, "beats with wrong data", bad_data, 0);
    chk(bad_last == 0, "R5", "beats with wrong last flag", bad_last, 0);
  endtask

  task automatic check_burst(input int idx, input logic [63:0] a, input int n,
                             input string req);
    chk(log_addr.size() > idx && log_addr[idx] == a, req, "burst address",
        (log_addr.size() > idx) ? longint'(log_addr[idx]) : -1, longint'(a));
    chk(log_beats.size() > idx && log_beats[idx] == n, req, "burst beats",
        (log_beats.size() > idx) ? log_beats[idx] : -1, n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R1", "status after reset", {busy_o, done_o, err_o}, 0);
    chk(!m_arvalid && !s_tvalid, "R1", "valids after reset", {m_arvalid, s_tvalid}, 0);
  endtask

  task automatic t_basic();
    int ma, ms, d0;
    ma = log_addr.size(); ms = s_log.size(); d0 = done_cnt;
    start_job(64'h0001_0010, 5);
    chk(busy_o, "R6", "busy after start", busy_o, 1);
    wait_done(d0);
    @(negedge clk);
    check_stream(64'h0001_0010, 5, ms, "R2");
    chk(log_addr.size() - ma == 1, "R3", "burst count", log_addr.size() - ma, 1);
    check_burst(ma, 64'h0001_0000, 5, "R3");
    chk(done_cyc == last_hs_cyc + 1, "R6", "done cycle after last beat", done_cyc, last_hs_cyc + 1);
    chk(!busy_o && !done_o, "R6", "idle after done", {busy_o, done_o}, 0);
  endtask

  task automatic t_long();
    int ma, ms, d0;
    ma = log_addr.size(); ms = s_log.size(); d0 = done_cnt;
    t_mode = 1; r_mode = 1; a_mode = 1;
    start_job(64'h0002_0000, 150);
    wait_done(d0);
    t_mode = 0; r_mode = 0; a_mode = 0;
    check_stream(64'h0002_0000, 150, ms, "R4");
    check_burst(ma,     64'h0002_0000, 64, "R3");
    check_burst(ma + 1, 64'h0002_1000, 64, "R3");
    check_burst(ma + 2, 64'h0002_2000, 22, "R3");
    chk(!ar_bad, "R3", "size or burst code wrong", ar_bad, 0);
    chk(!ar_drop, "R11", "request changed while stalled", ar_drop, 0);
    chk(!t_drop, "R4", "stream changed while stalled", t_drop, 0);
  endtask

  task automatic t_page();
    int ma, ms, d0;
    ma = log_addr.size(); ms = s_log.size(); d0 = done_cnt;
    start_job(64'h0000_3F40, 70);
    wait_done(d0);
    check_stream(64'h0000_3F40, 70, ms, "R2");
    chk(log_addr.size() - ma == 3, "R3", "page split burst count", log_addr.size() - ma, 3);
    check_burst(ma,     64'h0000_3F40, 3,  "R3");
    check_burst(ma + 1, 64'h0000_4000, 64, "R3");
    check_burst(ma + 2, 64'h0000_5000, 3,  "R3");
  endtask

  task automatic t_zero();
    int ma, ms;
    ma = log_addr.size(); ms = s_log.size();
    start_job(64'h0000_8000, 0);
    chk(done_o && !busy_o, "R7", "done pulse after zero length", {done_o, busy_o}, 2);
    @(negedge clk);
    chk(!done_o, "R7", "done falls", done_o, 0);
    repeat (5) @(negedge clk);
    chk(log_addr.size() == ma, "R7", "requests issued", log_addr.size() - ma, 0);
    chk(s_log.size() == ms && !s_tvalid, "R7", "stream beats", s_log.size() - ms, 0);
  endtask

  task automatic t_error();
    int ms, d0;
    ms = s_log.size(); d0 = done_cnt;
    err_en = 1'b1; err_addr = 64'h0004_00C0;
    start_job(64'h0004_0000, 8);
    wait_done(d0);
    @(negedge clk);
    err_en = 1'b0;
    chk(err_o, "R8", "error flag after bad response", err_o, 1);
    check_stream(64'h0004_0000, 8, ms, "R8");
    ms = s_log.size(); d0 = done_cnt;
    start_job(64'h0005_0000, 2);
    chk(!err_o, "R8", "error cleared by new start", err_o, 0);
    wait_done(d0);
    check_stream(64'h0005_0000, 2, ms, "R8");
  endtask

  task automatic t_credit();
    int ms, d0, r0, o0;
    ms = s_log.size(); d0 = done_cnt; r0 = req_beats; o0 = out_beats;
    t_mode = 2;
    start_job(64'h0006_0000, 300);
    repeat (400) @(negedge clk);
    chk(req_beats - r0 == 128, "R9", "beats requested while stalled", req_beats - r0, 128);
    chk(out_beats == o0, "R9", "beats streamed while stalled", out_beats - o0, 0);
    t_mode = 0;
    wait_done(d0);
    check_stream(64'h0006_0000, 300, ms, "R9");
  endtask

  task automatic t_busy_start();
    int ma, ms, d0;
    ma = log_addr.size(); ms = s_log.size(); d0 = done_cnt;
    t_mode = 1;
    start_job(64'h0007_0000, 40);
    repeat (3) @(negedge clk);
    base_addr_i = 64'h0009_0000; len_i = 16'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(d0);
    t_mode = 0;
    repeat (10) @(negedge clk);
    check_stream(64'h0007_0000, 40, ms, "R10");
    chk(log_addr.size() - ma == 1, "R10", "requests issued", log_addr.size() - ma, 1);
    chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_addr_i = '0; len_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !m_arvalid && !s_tvalid, "R1", "outputs in reset", 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_long();
    t_page();
    t_zero();
    t_error();
    t_credit();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule